// File: doc/BRIEF.md
# Byte-Register SPI Master Controller

This block is a single-master SPI controller that a host drives through a seven-entry, byte-wide register port. The host picks a clock polarity, a clock phase and a divider code, then writes bytes into a data register. Each byte is queued in a small transmit FIFO and shifted out MSB first while the byte on `miso` is collected. The received bytes collect in a receive FIFO, and the host reads them back from the same data register.

The SCK rate is the system clock divided by a power of two from 2 to 4096. A 4-bit code selects the divisor: its low half sits in the control register and its high half in the extended register. The mapping from code to divisor is deliberately not monotonic. Four chip-select outputs are driven by a packed byte. Its low nibble gives each line to software control and its high nibble gives each line its level.

A parameter-register bit marks a memory-mapped read mode. The block only stores that bit, and while it is set no register-driven transfer starts.

Top module: `spim_byte_ctrl`

## Requirements
- R1: After reset every register reads 0x00 except status, which reads 0x01 (receive FIFO empty). All chip-select outputs are high and SCK is low.
- R2: The divider code is {ext[1:0], ctrl[1:0]}. Codes 0,1,4,2,3 select divisors 2,4,8,16,32. Codes 5 to 11 select 2^(code+1). One SCK half period lasts divisor/2 system clocks. Codes 12 to 15 select 4096.
- R3: Writing the data register (offset 2) while enabled (ctrl bit 6) exchanges one byte MSB first in all four modes: ctrl bit 3 is CPOL and ctrl bit 2 is CPHA. CPHA=0 samples on the first edge of each bit and CPHA=1 samples on the second. Reading offset 2 returns the received byte and removes it.
- R4: Between transfers SCK rests at the CPOL level.
- R5: Status bit 7 sets when a byte completes. Writing 1 to status bit 7 clears it.
- R6: Status bit 0 reads 1 exactly while the receive FIFO is empty.
- R7: The transmit FIFO holds 4 bytes. A data write while it is full sets status bit 6 and drops the byte. Writing 1 to bit 6 clears it. Queued bytes go out, and come back, in write order.
- R8: Chip-select register (offset 5): for line n, if bit n is 0 then cs_n[n] is high; otherwise cs_n[n] equals bit n+4.
- R9: While parameter bit 0 (offset 4) is 1, no transfer starts and SCK does not toggle.
- R10: While ctrl bit 6 is 0, the shift engine is idle and both FIFOs are emptied. Bytes queued before the disable are never sent.
- R11: The extended (offset 3), parameter (offset 4) and timing (offset 6) registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset 0 to 6 |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a read of offset 2 pops the receive FIFO |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Chip-select outputs |

## Verification
The assertions assume that CPOL, CPHA and the divider code are not rewritten while a byte is shifting. They also assume that a write strobe and a read strobe are never raised in the same cycle. The stimulus changes the mode only after it has seen the completion flag and drained the data. It drives every register access as a single-cycle strobe between falling clock edges. The slave model in the bench assumes `miso` changes only on its own shift edge, and it drives `miso` that way.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int MAX_EXP = 12;

   typedef enum logic [2:0] {
      RS_CTRL  = 3'd0,
      RS_STAT  = 3'd1,
      RS_DATA  = 3'd2,
      RS_EXT   = 3'd3,
      RS_PARAM = 3'd4,
      RS_CSEL  = 3'd5,
      RS_TIME  = 3'd6,
      RS_NONE  = 3'd7
   } reg_sel_e;

   // log2 of the SCK divisor for a 4-bit divider code
   function automatic logic [3:0] div_exp(input logic [3:0] code);
      logic [3:0] e;
      case (code)
         4'd0:    e = 4'd1;
         4'd1:    e = 4'd2;
         4'd2:    e = 4'd4;
         4'd3:    e = 4'd5;
         4'd4:    e = 4'd3;
         4'd12, 4'd13, 4'd14, 4'd15: e = 4'(MAX_EXP);
         default: e = code + 4'd1;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spim_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
         if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            start,
   input  logic [BITS-1:0] tx_byte,
   input  logic            cpol,
   input  logic            cpha,
   input  logic [3:0]      div_code,
   input  logic            miso,
   output logic            busy,
   output logic            sck,
   output logic            mosi,
   output logic            rx_valid,
   output logic [BITS-1:0] rx_byte
);
   localparam int EDGES = 2 * BITS;
   localparam int EW    = $clog2(EDGES);
   localparam int CNTW  = MAX_EXP;

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("spim_engine: BITS must be at least 2");
      end
   endgenerate

   logic            busy_q, cpol_l, cpha_l, ph_q;
   logic [CNTW-1:0] half_l, cnt_q;
   logic [EW-1:0]   idx_q;
   logic [BITS-1:0] sh_q, rx_q;
   logic            tick, sample_now, shift_now, last_edge;

   assign tick       = busy_q && (cnt_q == half_l - CNTW'(1));
   assign sample_now = cpha_l ? idx_q[0] : !idx_q[0];
   assign shift_now  = cpha_l ? (!idx_q[0] && (idx_q != '0)) : idx_q[0];
   assign last_edge  = (idx_q == EW'(EDGES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cpol_l   <= 1'b0;
         cpha_l   <= 1'b0;
         ph_q     <= 1'b0;
         half_l   <= CNTW'(1);
         cnt_q    <= '0;
         idx_q    <= '0;
         sh_q     <= '0;
         rx_q     <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (!enable) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
         end else if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               cpol_l <= cpol;
               cpha_l <= cpha;
               half_l <= CNTW'(1) << (div_exp(div_code) - 4'd1);
               cnt_q  <= '0;
               idx_q  <= '0;
               ph_q   <= 1'b0;
               sh_q   <= tx_byte;
            end
         end else if (tick) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
            idx_q <= idx_q + EW'(1);
            if (sample_now) rx_q <= {rx_q[BITS-2:0], miso};
            if (shift_now)  sh_q <= {sh_q[BITS-2:0], 1'b0};
            if (last_edge) begin
               busy_q   <= 1'b0;
               rx_valid <= 1'b1;
               rx_byte  <= cpha_l ? {rx_q[BITS-2:0], miso} : rx_q;
            end
         end else begin
            cnt_q <= cnt_q + CNTW'(1);
         end
      end
   end

   assign busy = busy_q;
   assign sck  = busy_q ? (cpol_l ^ ph_q) : cpol;
   assign mosi = sh_q[BITS-1];

endmodule

// File: rtl/spim_byte_ctrl.sv
module spim_byte_ctrl
   import spim_pkg::*;
#(
   parameter int NCS        = 4,
   parameter int FIFO_DEPTH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     reg_addr,
   input  logic           reg_wr,
   input  logic           reg_rd,
   input  logic [7:0]     reg_wdata,
   output logic [7:0]     reg_rdata,
   output logic           sck,
   output logic           mosi,
   input  logic           miso,
   output logic [NCS-1:0] cs_n
);
   localparam int BYTE = 8;

   generate
      if (NCS < 1 || NCS > 4) begin : g_bad_ncs
         $error("spim_byte_ctrl: NCS must be 1 to 4");
      end
   endgenerate

   logic [7:0] ctrl_q, ext_q, param_q, cs_q, time_q;
   logic       done_q, wcol_q;

   logic            tx_full, tx_empty, rx_full, rx_empty;
   logic [BYTE-1:0] tx_dout, rx_dout, rx_byte;
   logic            eng_busy, rx_push, start;
   logic            en, mem_en, wr_data, rd_data;
   reg_sel_e        sel;

   assign sel     = reg_sel_e'(reg_addr);
   assign en      = ctrl_q[6];
   assign mem_en  = param_q[0];
   assign wr_data = reg_wr && (sel == RS_DATA);
   assign rd_data = reg_rd && (sel == RS_DATA);
   assign start   = en && !mem_en && !eng_busy && !rx_push && !tx_empty && !rx_full;

   spim_fifo #(.WIDTH(BYTE), .DEPTH(FIFO_DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .flush(!en),
      .push(wr_data && en), .din(reg_wdata),
      .pop(start), .dout(tx_dout),
      .full(tx_full), .empty(tx_empty)
   );

   spim_fifo #(.WIDTH(BYTE), .DEPTH(FIFO_DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .flush(!en),
      .push(rx_push), .din(rx_byte),
      .pop(rd_data), .dout(rx_dout),
      .full(rx_full), .empty(rx_empty)
   );

   spim_engine #(.BITS(BYTE)) i_eng (
      .clk(clk), .rst_n(rst_n), .enable(en), .start(start),
      .tx_byte(tx_dout), .cpol(ctrl_q[3]), .cpha(ctrl_q[2]),
      .div_code({ext_q[1:0], ctrl_q[1:0]}), .miso(miso),
      .busy(eng_busy), .sck(sck), .mosi(mosi),
      .rx_valid(rx_push), .rx_byte(rx_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ext_q   <= '0;
         param_q <= '0;
         cs_q    <= '0;
         time_q  <= '0;
         done_q  <= 1'b0;
         wcol_q  <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (sel)
               RS_CTRL:  ctrl_q  <= reg_wdata;
               RS_EXT:   ext_q   <= reg_wdata;
               RS_PARAM: param_q <= reg_wdata;
               RS_CSEL:  cs_q    <= reg_wdata;
               RS_TIME:  time_q  <= reg_wdata;
               default:  ;
            endcase
         end
         if (rx_push)
            done_q <= 1'b1;
         else if (reg_wr && sel == RS_STAT && reg_wdata[7])
            done_q <= 1'b0;
         if (wr_data && en && tx_full)
            wcol_q <= 1'b1;
         else if (reg_wr && sel == RS_STAT && reg_wdata[6])
            wcol_q <= 1'b0;
      end
   end

   always_comb begin
      case (sel)
         RS_CTRL:  reg_rdata = ctrl_q;
         RS_STAT:  reg_rdata = {done_q, wcol_q, 5'b0, rx_empty};
         RS_DATA:  reg_rdata = rx_dout;
         RS_EXT:   reg_rdata = ext_q;
         RS_PARAM: reg_rdata = param_q;
         RS_CSEL:  reg_rdata = cs_q;
         RS_TIME:  reg_rdata = time_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   for (genvar g = 0; g < NCS; g++) begin : g_cs
      assign cs_n[g] = cs_q[g] ? cs_q[g+4] : 1'b1;
   end

endmodule

// File: rtl/spim_byte_ctrl_chk.sv
module spim_byte_ctrl_chk #(
   parameter int NCS = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [2:0]     reg_addr,
   input logic           reg_wr,
   input logic [7:0]     reg_wdata,
   input logic           sck,
   input logic [NCS-1:0] cs_n,
   input logic [7:0]     ctrl_q,
   input logic [7:0]     param_q,
   input logic           eng_busy,
   input logic           tx_full,
   input logic           tx_empty,
   input logic           rx_empty,
   input logic           done_q,
   input logic           wcol_q,
   input logic           rx_push
);

   p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == 3'd5) |=> $stable(cs_n));

   p_idle_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (sck == ctrl_q[3]));

   p_memmode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (param_q[0] && !eng_busy) |=> !eng_busy);

   p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd2 && ctrl_q[6] && tx_full) |=> wcol_q);

   p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd1 && reg_wdata[7] && !rx_push) |=> !done_q);

   p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> done_q);

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[6] |=> (tx_empty && rx_empty && !eng_busy));

endmodule

bind spim_byte_ctrl spim_byte_ctrl_chk #(.NCS(NCS)) i_chk (.*);

// File: tb/test_spim_byte_ctrl.sv
module test_spim_byte_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       sck, mosi, miso;
   logic [3:0] cs_n;

   spim_byte_ctrl i_spim_byte_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0, checks = 0;
   bit finished = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // slave model and scoreboard queues
   logic [7:0] exp_mosi[$];
   logic [7:0] slv_q[$];
   logic [7:0] stx = '0, srx = '0;
   int         scnt = 0, lead_n = 0;
   bit         skip = 0, slv_on = 0, cfg_cpol = 0, cfg_cpha = 0;
   assign miso = stx[7];

   always @(sck) begin
      if (slv_on) begin
         if ((sck != cfg_cpol) == !cfg_cpha) begin
            srx = {srx[6:0], mosi};
            scnt++;
         end else if (!cfg_cpha) begin
            if (skip) skip = 0; else stx = {stx[6:0], 1'b0};
         end else begin
            if (lead_n != 0) stx = {stx[6:0], 1'b0};
            lead_n++;
         end
         if (scnt == 8) begin
            scnt = 0;
            if (exp_mosi.size() == 0) chk("R3 unexpected byte on mosi", srx, 0);
            else chk("R3 mosi byte MSB first", srx, exp_mosi.pop_front());
            if (slv_q.size() != 0) begin
               stx = slv_q.pop_front();
               lead_n = 0;
               skip = 1;
            end
         end
      end
   end

   // SCK half-period monitor
   int cyc = 0, last_t = 0, gap_min = 0, gap_max = 0, edges = 0, toggles = 0;
   always @(negedge clk) cyc++;
   always @(sck) begin
      toggles++;
      if (edges > 0) begin
         if (edges == 1 || cyc - last_t < gap_min) gap_min = cyc - last_t;
         if (edges == 1 || cyc - last_t > gap_max) gap_max = cyc - last_t;
      end
      last_t = cyc;
      edges++;
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic prime(input logic [7:0] s);
      stx = s; lead_n = 0; skip = 0; scnt = 0;
   endtask

   task automatic set_mode(input bit pol, input bit pha, input logic [3:0] code);
      cfg_cpol = pol; cfg_cpha = pha;
      wr(3'd0, {1'b0, 1'b1, 2'b00, pol, pha, code[1:0]});
      wr(3'd3, {6'b0, code[3:2]});
   endtask

   task automatic wait_done();
      logic [7:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(3'd1, s);
         if (s[7]) break;
      end
      chk("R5 done flag set", s[7], 1);
      chk("R6 rx not empty after byte", s[0], 0);
      wr(3'd1, 8'h80);
      rd(3'd1, s);
      chk("R5 done flag cleared by writing 1", s[7], 0);
   endtask

   task automatic xfer(input bit pol, input bit pha, input logic [3:0] code,
                       input logic [7:0] m, input logic [7:0] s, input int half);
      logic [7:0] d;
      set_mode(pol, pha, code);
      prime(s);
      exp_mosi.push_back(m);
      edges = 0;
      slv_on = 1;
      wr(3'd2, m);
      wait_done();
      slv_on = 0;
      chk("R2 sck half period min", gap_min, half);
      chk("R2 sck half period max", gap_max, half);
      chk("R4 sck idles at CPOL", sck, pol);
      rd(3'd2, d);
      chk("R3 received byte", d, s);
      rd(3'd1, d);
      chk("R6 rx empty after read", d[0], 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cs_n reset", cs_n, 4'hF);
      chk("R1 sck reset", sck, 0);
      rd(3'd1, d); chk("R1 status reset", d, 8'h01);
      rd(3'd0, d); chk("R1 ctrl reset", d, 8'h00);
      rd(3'd4, d); chk("R1 param reset", d, 8'h00);
      rd(3'd5, d); chk("R1 csel reset", d, 8'h00);

      // R8 chip selects
      wr(3'd5, 8'h11); @(negedge clk); chk("R8 cs0 enabled high", cs_n, 4'hF);
      wr(3'd5, 8'h24); @(negedge clk); chk("R8 cs2 low, cs1 level ignored", cs_n, 4'b1011);
      wr(3'd5, 8'h01); @(negedge clk); chk("R8 cs0 asserted low", cs_n, 4'b1110);

      // R2 / R3 / R4 single bytes across modes and divider codes
      xfer(0, 0, 4'd0, 8'hA5, 8'h3C, 1);
      xfer(0, 1, 4'd1, 8'h5A, 8'hC3, 2);
      xfer(1, 0, 4'd4, 8'h81, 8'h7E, 4);
      xfer(1, 1, 4'd2, 8'h0F, 8'hF0, 8);
      xfer(0, 0, 4'd3, 8'h6B, 8'hD2, 16);
      xfer(1, 1, 4'd5, 8'h96, 8'h69, 32);

      // R9 / R7: queue with memory mode set, overflow the transmit FIFO
      wr(3'd4, 8'h01);
      set_mode(0, 0, 4'd0);
      prime(8'h11);
      slv_q.push_back(8'h22); slv_q.push_back(8'h33); slv_q.push_back(8'h44);
      exp_mosi.push_back(8'hC1); exp_mosi.push_back(8'hC2);
      exp_mosi.push_back(8'hC3); exp_mosi.push_back(8'hC4);
      slv_on = 1;
      t0 = toggles;
      wr(3'd2, 8'hC1); wr(3'd2, 8'hC2); wr(3'd2, 8'hC3);
      wr(3'd2, 8'hC4); wr(3'd2, 8'hC5);
      idle(40);
      chk("R9 no sck toggles in memory mode", toggles - t0, 0);
      rd(3'd1, d);
      chk("R9 nothing received in memory mode", d[0], 1);
      chk("R7 collision flag set on full write", d[6], 1);
      wr(3'd1, 8'h40);
      rd(3'd1, d);
      chk("R7 collision flag cleared", d[6], 0);
      wr(3'd4, 8'h00);
      idle(300);
      slv_on = 0;
      rd(3'd2, d); chk("R7 first byte in order", d, 8'h11);
      rd(3'd2, d); chk("R7 second byte in order", d, 8'h22);
      rd(3'd2, d); chk("R7 third byte in order", d, 8'h33);
      rd(3'd2, d); chk("R7 fourth byte in order", d, 8'h44);
      rd(3'd1, d); chk("R7 fifth byte dropped", d[0], 1);
      chk("R3 all queued bytes seen by slave", exp_mosi.size(), 0);
      wr(3'd1, 8'h80);

      // R10: bytes queued, then disable flushes them
      wr(3'd4, 8'h01);
      wr(3'd2, 8'hE1); wr(3'd2, 8'hE2);
      wr(3'd0, 8'h00);
      wr(3'd0, 8'h40);
      t0 = toggles;
      wr(3'd4, 8'h00);
      idle(100);
      chk("R10 no sck after flush", toggles - t0, 0);
      rd(3'd1, d);
      chk("R10 rx empty after flush", d[0], 1);
      chk("R10 no completion after flush", d[7], 0);

      // R11 held registers
      wr(3'd6, 8'h5C); rd(3'd6, d); chk("R11 timing readback", d, 8'h5C);
      wr(3'd3, 8'hA3); rd(3'd3, d); chk("R11 ext readback", d, 8'hA3);
      wr(3'd4, 8'h80); rd(3'd4, d); chk("R11 param readback", d, 8'h80);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule